// File: doc/BRIEF.md
# SDRAM Bank Activation Timing Guard

This block sits between a memory scheduler and the command path of a four-bank SDRAM. On every clock it looks at one requested command (bank, row and command type) and decides in the same cycle whether that command may issue. A granted ACTIVE opens the row in its bank. A granted PRECHARGE closes it. READ and WRITE are allowed only to the row that is open. A request that may not issue yet is stalled, and the caller keeps presenting it until it is granted.

Three activation spacings are enforced: row-to-column delay, same-bank row-cycle time and cross-bank row-to-row delay. Each is given in nanoseconds and converted at elaboration to whole clocks by rounding up against the clock period. Per-bank down-counters and one shared counter hold the remaining wait. The block also reports which banks hold an open row and which row that is. It raises a row-miss flag when a column access targets a row other than the open one, so the caller knows to precharge and reactivate.

Top module: `sdram_act_guard`

## Requirements
- R1: After reset all banks are closed, all timers are expired, and an ACTIVE presented in the first cycle after reset is granted.
- R2: A READ or WRITE is granted only when its bank is open and the requested row equals the open row. A column request to a closed bank is stalled with row_miss_o low.
- R3: A READ or WRITE to an open bank whose open row differs from the requested row is stalled, and row_miss_o is raised in that cycle.
- R4: A READ or WRITE to a bank is granted no earlier than the clock edge that lies tRCD clocks after the edge that committed that bank's ACTIVE. With 20 ns and an 8 ns clock this is the third edge.
- R5: An ACTIVE to a bank that already holds an open row is stalled, whether the row is the same or different, until that bank is precharged.
- R6: Two ACTIVEs to the same bank are at least tRC clocks apart (60 ns at 8 ns gives 8), even when a PRECHARGE has closed the bank in between.
- R7: Two ACTIVEs to different banks are at least tRRD clocks apart (12 ns at 8 ns gives 2).
- R8: A PRECHARGE is always granted and closes the addressed bank from the next cycle. A PRECHARGE to a closed bank leaves every bank's state unchanged.
- R9: Command codes on req_cmd_i are 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE and 4 PRECHARGE, and codes 5 to 7 act as NOP. With req_valid_i low or a NOP code, grant_o and stall_o are low. Otherwise stall_o is the inverse of grant_o.
- R10: Every clock count is the ceiling of (ns * 1000) / period_ps, taken in integer picoseconds.
- R11: bank_open_o bit b and open_row_o bits [b*12 +: 12] report bank b's open flag and the row of its last granted ACTIVE, from the cycle after the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_cmd_i | input | 3 | Command code |
| req_bank_i | input | 2 | Target bank |
| req_row_i | input | 12 | Row address |
| grant_o | output | 1 | Request may issue this cycle |
| stall_o | output | 1 | Valid command held back this cycle |
| row_miss_o | output | 1 | Column access targets a row other than the open one |
| bank_open_o | output | 4 | Open flag per bank |
| open_row_o | output | 48 | Open row per bank, 12 bits each |

## Verification
The functions that meet in one cycle are the expiry of a timer and the arrival of the request that waits on it. The other case is a PRECHARGE that closes a bank while that bank's row-cycle timer is still running. Sweeps place the dependent request at every distance from the ACTIVE, from zero up to past the limit. Each attempt is expected granted exactly when the distance reaches the clock count that the bench derives by ceiling division. In the same-bank sweep a PRECHARGE always falls between the two ACTIVEs. The bench then checks that the closed bank still refuses activation until the row-cycle count has run out.

// File: rtl/sdram_act_guard_pkg.sv
package sdram_act_guard_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  // ceiling of ns / period, integer picoseconds
  function automatic int ns_to_cyc(input int ns, input int period_ps);
    return (ns * 1000 + period_ps - 1) / period_ps;
  endfunction
endpackage

// File: rtl/sdram_dn_timer.sv
module sdram_dn_timer #(
  parameter int LOAD = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic zero_o
);
  localparam int W = (LOAD > 2) ? $clog2(LOAD) : 1;
  localparam logic [W-1:0] LV = (LOAD > 0) ? W'(LOAD - 1) : '0;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= LV;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // expired timer stays expired until reloaded
  p_tmr_sat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o);
endmodule

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot #(
  parameter int ROW_W = 12,
  parameter int RCD_C = 3,
  parameter int RC_C  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             rcd_ok_o,
  output logic             rc_ok_o
);
  logic             open_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (act_i) begin
      open_q <= 1'b1;
      row_q  <= row_i;
    end else if (pre_i) begin
      open_q <= 1'b0;
    end
  end

  sdram_dn_timer #(.LOAD(RCD_C)) u_rcd (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(act_i), .zero_o(rcd_ok_o));
  sdram_dn_timer #(.LOAD(RC_C)) u_rc (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(act_i), .zero_o(rc_ok_o));

  assign open_o = open_q;
  assign row_o  = row_q;

  p_act_opens_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> (open_o && row_o == $past(row_i)));
  p_pre_closes_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_i && !act_i) |=> !open_o);
  if (RC_C > 1) begin : g_rc_chk
    p_rc_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_i |=> !rc_ok_o);
  end
endmodule

// File: rtl/sdram_act_guard.sv
module sdram_act_guard
  import sdram_act_guard_pkg::*;
#(
  parameter int PERIOD_PS = 8000,
  parameter int TRCD_NS   = 20,
  parameter int TRC_NS    = 60,
  parameter int TRRD_NS   = 12,
  parameter int BANKS     = 4,
  parameter int ROW_W     = 12
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  input  logic [2:0]             req_cmd_i,
  input  logic [1:0]             req_bank_i,
  input  logic [11:0]            req_row_i,
  output logic                   grant_o,
  output logic                   stall_o,
  output logic                   row_miss_o,
  output logic [3:0]             bank_open_o,
  output logic [47:0]            open_row_o
);
  localparam int RCD_C  = ns_to_cyc(TRCD_NS, PERIOD_PS);
  localparam int RC_C   = ns_to_cyc(TRC_NS, PERIOD_PS);
  localparam int RRD_C  = ns_to_cyc(TRRD_NS, PERIOD_PS);
  localparam int BANK_W = $clog2(BANKS);

  cmd_e             cmd;
  logic [BANKS-1:0] open_v, rcd_ok_v, rc_ok_v, act_v, pre_v;
  logic [ROW_W-1:0] row_v [BANKS];
  logic             rrd_ok, ok, is_col, is_cmd, hit, act_gnt, pre_gnt;
  logic [BANK_W-1:0] bank;

  assign bank = req_bank_i[BANK_W-1:0];

  always_comb begin
    cmd = CMD_NOP;
    case (req_cmd_i)
      3'd1: cmd = CMD_ACT;
      3'd2: cmd = CMD_RD;
      3'd3: cmd = CMD_WR;
      3'd4: cmd = CMD_PRE;
      default: cmd = CMD_NOP;
    endcase
  end

  always_comb begin
    is_col = (cmd == CMD_RD) || (cmd == CMD_WR);
    is_cmd = (cmd != CMD_NOP);
    hit    = (row_v[bank] == req_row_i[ROW_W-1:0]);
    case (cmd)
      CMD_ACT: ok = !open_v[bank] && rc_ok_v[bank] && rrd_ok;
      CMD_RD,
      CMD_WR:  ok = open_v[bank] && hit && rcd_ok_v[bank];
      CMD_PRE: ok = 1'b1;
      default: ok = 1'b0;
    endcase
  end

  assign grant_o    = req_valid_i && ok;
  assign stall_o    = req_valid_i && is_cmd && !ok;
  assign row_miss_o = req_valid_i && is_col && open_v[bank] && !hit;
  assign act_gnt    = grant_o && (cmd == CMD_ACT);
  assign pre_gnt    = grant_o && (cmd == CMD_PRE);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign act_v[b] = act_gnt && (bank == BANK_W'(b));
    assign pre_v[b] = pre_gnt && (bank == BANK_W'(b));
    sdram_bank_slot #(.ROW_W(ROW_W), .RCD_C(RCD_C), .RC_C(RC_C)) u_slot (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .act_i(act_v[b]), .pre_i(pre_v[b]), .row_i(req_row_i[ROW_W-1:0]),
      .open_o(open_v[b]), .row_o(row_v[b]),
      .rcd_ok_o(rcd_ok_v[b]), .rc_ok_o(rc_ok_v[b]));
    assign bank_open_o[b] = open_v[b];
    assign open_row_o[b*ROW_W +: ROW_W] = row_v[b];
  end

  sdram_dn_timer #(.LOAD(RRD_C)) u_rrd (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(act_gnt), .zero_o(rrd_ok));

  p_col_open_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && is_col) |-> bank_open_o[req_bank_i]);
  p_miss_stalls_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_miss_o |-> (stall_o && !grant_o));
  p_act_closed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_gnt |-> !bank_open_o[req_bank_i]);
  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (!grant_o && !stall_o && !row_miss_o));
  p_one_act_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(act_v));
  if (RRD_C > 1) begin : g_rrd_chk
    p_act_spacing_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_gnt |=> !act_gnt);
  end
endmodule

// File: tb/sdram_act_guard_bench.sv
`timescale 1ns/1ps
module sdram_act_guard_bench;
  localparam int CLK_NS = 8;
  localparam int PS     = CLK_NS * 1000;
  localparam int E_RCD  = (20 * 1000 + PS - 1) / PS;
  localparam int E_RC   = (60 * 1000 + PS - 1) / PS;
  localparam int E_RRD  = (12 * 1000 + PS - 1) / PS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic [1:0] bank = 2'd0;
  logic [11:0] row = 12'd0;
  logic grant, stall, miss;
  logic [3:0] bopen;
  logic [47:0] orow;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_NS / 2) clk = ~clk;

  sdram_act_guard #(.PERIOD_PS(PS), .TRCD_NS(20), .TRC_NS(60), .TRRD_NS(12))
  u_sdram_act_guard (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_cmd_i(cmd),
    .req_bank_i(bank), .req_row_i(row), .grant_o(grant), .stall_o(stall),
    .row_miss_o(miss), .bank_open_o(bopen), .open_row_o(orow));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [2:0] c, input logic [1:0] b,
                       input logic [11:0] r);
    @(negedge clk);
    valid = v; cmd = c; bank = b; row = r;
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 3'd0, 2'd0, 12'd0);
  endtask

  task automatic settle();
    for (int b = 0; b < 4; b++) drive(1'b1, 3'd4, 2'(b), 12'd0);
    idle(E_RC + 1);
  endtask

  initial begin
    #(200000 * CLK_NS);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(2);
    chk("R1 reset open", int'(bopen), 0);
    chk("R1 reset grant", int'(grant), 0);
    @(negedge clk); rst_n = 1'b1;
    drive(1'b1, 3'd1, 2'd0, 12'd5);
    chk("R1 act after reset", int'(grant), 1);
    idle(1);
    chk("R11 open flag", int'(bopen), 1);
    chk("R11 open row", int'(orow[11:0]), 5);
    drive(1'b1, 3'd1, 2'd0, 12'd5);
    chk("R5 act same row", int'(grant), 0);
    chk("R5 act same row stall", int'(stall), 1);
    drive(1'b1, 3'd1, 2'd0, 12'd6);
    chk("R5 act other row", int'(grant), 0);
    idle(E_RCD);
    drive(1'b1, 3'd2, 2'd0, 12'd9);
    chk("R3 miss grant", int'(grant), 0);
    chk("R3 miss flag", int'(miss), 1);
    chk("R3 miss stall", int'(stall), 1);
    drive(1'b1, 3'd2, 2'd0, 12'd5);
    chk("R2 hit grant", int'(grant), 1);
    chk("R2 hit miss", int'(miss), 0);
    drive(1'b1, 3'd3, 2'd2, 12'd5);
    chk("R2 closed grant", int'(grant), 0);
    chk("R2 closed miss", int'(miss), 0);
    chk("R2 closed stall", int'(stall), 1);
    drive(1'b0, 3'd2, 2'd0, 12'd5);
    chk("R9 invalid grant", int'(grant), 0);
    chk("R9 invalid stall", int'(stall), 0);
    for (int c = 5; c < 8; c++) begin
      drive(1'b1, 3'(c), 2'd0, 12'd5);
      chk("R9 spare code grant", int'(grant), 0);
      chk("R9 spare code stall", int'(stall), 0);
    end
    drive(1'b1, 3'd0, 2'd0, 12'd5);
    chk("R9 nop stall", int'(stall), 0);
    drive(1'b1, 3'd4, 2'd0, 12'd0);
    chk("R8 pre grant", int'(grant), 1);
    drive(1'b1, 3'd4, 2'd3, 12'd0);
    chk("R8 pre closed grant", int'(grant), 1);
    chk("R8 bank closed", int'(bopen), 0);
    idle(1);
    chk("R8 no change", int'(bopen), 0);
    chk("R8 row kept", int'(orow[11:0]), 5);

    settle();
    for (int b = 0; b < 4; b++) begin
      drive(1'b1, 3'd1, 2'(b), 12'(100 + 7 * b));
      chk("R11 act grant", int'(grant), 1);
      idle(E_RRD);
    end
    chk("R11 all open", int'(bopen), 15);
    for (int b = 0; b < 4; b++)
      chk("R11 row slice", int'(orow[b*12 +: 12]), 100 + 7 * b);

    // R4, R10: row-to-column distance sweep
    for (int d = 0; d < 6; d++) begin
      settle();
      drive(1'b1, 3'd1, 2'd1, 12'd3);
      idle(d);
      drive(1'b1, (d % 2) ? 3'd3 : 3'd2, 2'd1, 12'd3);
      chk("R4 rcd sweep", int'(grant), int'(d + 1 >= E_RCD));
    end
    // R6, R10: same-bank with precharge in between
    for (int k = 2; k < 11; k++) begin
      settle();
      drive(1'b1, 3'd1, 2'd2, 12'd1);
      drive(1'b1, 3'd4, 2'd2, 12'd0);
      idle(k - 2);
      drive(1'b1, 3'd1, 2'd2, 12'd1);
      chk("R6 rc sweep", int'(grant), int'(k >= E_RC));
    end
    // R7, R10: cross-bank spacing
    for (int d = 0; d < 5; d++) begin
      settle();
      drive(1'b1, 3'd1, 2'd0, 12'd2);
      idle(d);
      drive(1'b1, 3'd1, 2'd3, 12'd2);
      chk("R7 rrd sweep", int'(grant), int'(d + 1 >= E_RRD));
    end
    idle(1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule